// File: doc/BRIEF.md
# Line-Synchronous Serial Control Register

This block takes a 19-bit control word over a three-wire serial port (shift clock, data, strobe) that is asynchronous to the system clock. A strobe edge copies the word into a shadow register. The block then feeds the word to a sensor timing core in three groups. Each group is released at its own point in time:

- The four 2-bit phase-select fields take effect as soon as the strobe latches.
- The 2-bit shutter mode waits for the first horizontal line start that occurs while the readout pulse is active.
- The 9-bit shutter speed waits for the next readout line after that.

This two-step staging keeps a change of shutter exposure aligned with frame readout. The shutter pulse generator that consumes these fields is not part of this block.

All three serial pins pass through two-flop synchronisers. Edges are detected in the system clock domain. The line-start pulse and the readout-active flag are already synchronous to the system clock.

Top module: `sercfg_linesync`

## Requirements
- R1: While reset is asserted, and after it is released, the speed, mode and all four phase outputs read zero until a word is committed.
- R2: Each rising edge of the shift clock shifts in one data bit, first bit first. After 19 or more edges the word holds the last 19 bits sent. The first of those bits is word bit 0 and the last is word bit 18.
- R3: A rising strobe edge latches the word. The phase outputs then update at once from these word bits: reset-pulse phase = bits 12:11, clamp phase = bits 14:13, sample phase = bits 16:15, S/H phase = bits 18:17. In each pair the lower index is the LSB.
- R4: The shutter mode output (word bits 10:9) takes the latched value at the first line-start pulse after the strobe that occurs while readout-active is high.
- R5: The shutter speed output (word bits 8:0) takes the latched value at the next line-start pulse with readout-active high after the mode commit. Never earlier.
- R6: A line-start pulse while readout-active is low commits nothing.
- R7: A strobe that arrives before staging completes replaces the pending values, and staging restarts from the mode step. If a strobe edge and a readout line start fall in the same system clock cycle, the strobe wins and that line commits nothing.
- R8: Shifting bits without a strobe changes none of the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data (asynchronous) |
| ser_stb_i | input | 1 | Serial strobe; its rising edge latches the word (asynchronous) |
| line_start_i | input | 1 | One-cycle pulse at the start of each horizontal line |
| rdout_act_i | input | 1 | High during lines in which the readout pulse is active |
| speed_o | output | 9 | Active shutter speed |
| mode_o | output | 2 | Active shutter mode |
| ph_rst_o | output | 2 | Reset-pulse phase select |
| ph_clamp_o | output | 2 | CDS clamp phase select |
| ph_samp_o | output | 2 | CDS sample phase select |
| ph_sh_o | output | 2 | S/H phase select |

## Verification
The bench targets the staging order.

- A design that commits speed together with mode shows a new speed one readout line too early.
- A design that counts non-readout lines commits on the wrong line.
- The bench sends overlong bursts before a strobe. A design that keeps the first 19 bits instead of the last shows wrong fields.
- The bench also places a strobe in the same cycle as a readout line start, and a second strobe between the mode and speed steps. A stager that does not restart commits stale or mixed values.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int SPD_W   = 9;
  localparam int MODE_W  = 2;
  localparam int PH_W    = 2;
  localparam int PH_N    = 4;
  localparam int WORD_W  = SPD_W + MODE_W + PH_W * PH_N;
  localparam int MODE_LSB = SPD_W;
  localparam int PH_LSB   = SPD_W + MODE_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_WAIT_MODE  = 2'd1,
    ST_WAIT_SPEED = 2'd2
  } stage_e;

  function automatic word_t shift_in(input word_t w, input logic b);
    return {b, w[WORD_W-1:1]};
  endfunction

  function automatic logic [SPD_W-1:0] get_speed(input word_t w);
    return w[SPD_W-1:0];
  endfunction

  function automatic logic [MODE_W-1:0] get_mode(input word_t w);
    return w[MODE_LSB +: MODE_W];
  endfunction

  function automatic logic [PH_W-1:0] get_phase(input word_t w, input int idx);
    return w[PH_LSB + idx*PH_W +: PH_W];
  endfunction
endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/sercfg_shifter.sv
module sercfg_shifter
  import sercfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sclk_s,
  input  logic  sdat_s,
  input  logic  stb_s,
  output word_t shadow_o,
  output logic  stb_rise_o
);
  logic  sclk_q, stb_q;
  logic  sclk_rise;
  word_t shreg;

  assign sclk_rise  = sclk_s & ~sclk_q;
  assign stb_rise_o = stb_s & ~stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      stb_q    <= 1'b0;
      shreg    <= '0;
      shadow_o <= '0;
    end else begin
      sclk_q <= sclk_s;
      stb_q  <= stb_s;
      if (sclk_rise)  shreg    <= shift_in(shreg, sdat_s);
      if (stb_rise_o) shadow_o <= shreg;
    end
  end

  // R2
  shift_only_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shreg != $past(shreg)) |-> $past(sclk_rise));

  // R8
  shadow_only_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_o != $past(shadow_o)) |-> $past(stb_rise_o));
endmodule

// File: rtl/sercfg_stager.sv
module sercfg_stager
  import sercfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_rise_i,
  input  logic              line_start_i,
  input  logic              rdout_act_i,
  input  word_t             shadow_i,
  output logic [SPD_W-1:0]  speed_o,
  output logic [MODE_W-1:0] mode_o
);
  stage_e stage_q;
  logic   commit_line, mode_commit, speed_commit;

  assign commit_line  = line_start_i & rdout_act_i & ~stb_rise_i;
  assign mode_commit  = commit_line & (stage_q == ST_WAIT_MODE);
  assign speed_commit = commit_line & (stage_q == ST_WAIT_SPEED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_IDLE;
      speed_o <= '0;
      mode_o  <= '0;
    end else if (stb_rise_i) begin
      stage_q <= ST_WAIT_MODE;
    end else if (mode_commit) begin
      mode_o  <= get_mode(shadow_i);
      stage_q <= ST_WAIT_SPEED;
    end else if (speed_commit) begin
      speed_o <= get_speed(shadow_i);
      stage_q <= ST_IDLE;
    end
  end

  // R4
  mode_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != $past(mode_o)) |-> $past(line_start_i && rdout_act_i));

  // R5
  speed_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_o != $past(speed_o)) |-> $past(line_start_i && rdout_act_i && stage_q == ST_WAIT_SPEED));

  // R5
  not_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((speed_o != $past(speed_o)) && (mode_o != $past(mode_o))));

  // R7
  strobe_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_rise_i |=> (stage_q == ST_WAIT_MODE && $stable(mode_o) && $stable(speed_o)));
endmodule

// File: rtl/sercfg_linesync.sv
module sercfg_linesync
  import sercfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_stb_i,
  input  logic              line_start_i,
  input  logic              rdout_act_i,
  output logic [SPD_W-1:0]  speed_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [PH_W-1:0]   ph_rst_o,
  output logic [PH_W-1:0]   ph_clamp_o,
  output logic [PH_W-1:0]   ph_samp_o,
  output logic [PH_W-1:0]   ph_sh_o
);
  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0]    ser_s;
  word_t                shadow;
  logic                 stb_rise;
  logic [PH_W-1:0]      ph_arr [PH_N];

  sercfg_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({ser_stb_i, ser_dat_i, ser_clk_i}),
    .q_o  (ser_s)
  );

  sercfg_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (ser_s[0]),
    .sdat_s    (ser_s[1]),
    .stb_s     (ser_s[2]),
    .shadow_o  (shadow),
    .stb_rise_o(stb_rise)
  );

  sercfg_stager u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb_rise_i  (stb_rise),
    .line_start_i(line_start_i),
    .rdout_act_i (rdout_act_i),
    .shadow_i    (shadow),
    .speed_o     (speed_o),
    .mode_o      (mode_o)
  );

  for (genvar p = 0; p < PH_N; p++) begin : g_ph
    assign ph_arr[p] = get_phase(shadow, p);
  end

  assign ph_rst_o   = ph_arr[0];
  assign ph_clamp_o = ph_arr[1];
  assign ph_samp_o  = ph_arr[2];
  assign ph_sh_o    = ph_arr[3];

  // R3
  phase_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({ph_sh_o, ph_samp_o, ph_clamp_o, ph_rst_o} != $past({ph_sh_o, ph_samp_o, ph_clamp_o, ph_rst_o}))
      |-> $past(stb_rise));

  // R6
  idle_line_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start_i && !rdout_act_i) |=> ($stable(mode_o) && $stable(speed_o)));
endmodule

// File: tb/sercfg_linesync_tb_top.sv
module sercfg_linesync_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_stb = 1'b0;
  logic line_start = 1'b0, rdout_act = 1'b0;
  logic [8:0] speed;
  logic [1:0] mode, ph_rst, ph_clamp, ph_samp, ph_sh;

  int n_chk = 0;
  int n_bad = 0;

  logic [18:0] m_shift = '0, m_pend = '0;
  logic [8:0]  e_speed = '0;
  logic [1:0]  e_mode = '0;
  logic [7:0]  e_ph = '0;
  int          m_stage = 0;

  always #5 clk = ~clk;

  sercfg_linesync dut_i (
    .clk(clk), .rst_n(rst_n),
    .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_stb_i(ser_stb),
    .line_start_i(line_start), .rdout_act_i(rdout_act),
    .speed_o(speed), .mode_o(mode),
    .ph_rst_o(ph_rst), .ph_clamp_o(ph_clamp), .ph_samp_o(ph_samp), .ph_sh_o(ph_sh)
  );

  function automatic logic [18:0] add_bit(input logic [18:0] w, input logic b);
    return {b, w[18:1]};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " speed"}, speed, e_speed);
    check({tag, " mode"},  mode,  e_mode);
    check({tag, " R3 rst phase"},   ph_rst,   e_ph[1:0]);
    check({tag, " R3 clamp phase"}, ph_clamp, e_ph[3:2]);
    check({tag, " R3 samp phase"},  ph_samp,  e_ph[5:4]);
    check({tag, " R3 sh phase"},    ph_sh,    e_ph[7:6]);
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b; ser_clk = 1'b0; wait_neg(3);
    ser_clk = 1'b1; wait_neg(3);
    ser_clk = 1'b0;
    m_shift = add_bit(m_shift, b);
  endtask

  task automatic send_word(input logic [18:0] w, input int extra);
    for (int i = 0; i < extra; i++) send_bit(1'($urandom));
    for (int i = 0; i < 19; i++) send_bit(w[i]);
  endtask

  task automatic model_strobe();
    m_pend = m_shift; e_ph = m_pend[18:11]; m_stage = 1;
  endtask

  task automatic strobe();
    ser_stb = 1'b1; wait_neg(3);
    ser_stb = 1'b0; wait_neg(3);
    model_strobe();
  endtask

  task automatic line(input logic act);
    line_start = 1'b1; rdout_act = act;
    wait_neg(1);
    line_start = 1'b0; rdout_act = 1'b0;
    wait_neg(1);
    if (act) begin
      if (m_stage == 1) begin e_mode = m_pend[10:9]; m_stage = 2; end
      else if (m_stage == 2) begin e_speed = m_pend[8:0]; m_stage = 0; end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a1c));
    wait_neg(3);
    check_all("R1 in reset");
    rst_n = 1'b1;
    wait_neg(2);
    check_all("R1 after reset");

    // Directed: full staging sequence
    send_word(19'h5_A5C3, 0);
    check_all("R8 shift without strobe");
    strobe();
    check_all("R3 strobe phase");
    line(1'b0);
    check_all("R6 non-readout line");
    line(1'b1);
    check_all("R4 mode step");
    check("R5 speed not yet", speed, 0);
    line(1'b0);
    check_all("R6 between steps");
    line(1'b1);
    check_all("R5 speed step");
    line(1'b1);
    check_all("R5 idle after staging");

    // Directed: overlong burst keeps last 19 bits
    send_word(19'h3_1F0E, 7);
    strobe();
    check_all("R2 overlong burst");
    line(1'b1); line(1'b1);
    check_all("R2 overlong committed");
    check("R2 speed value", speed, 19'h3_1F0E & 9'h1FF);

    // Directed: re-strobe between steps restarts staging
    send_word(19'h6_0155, 0);
    strobe();
    line(1'b1);
    check_all("R7 first mode");
    send_word(19'h1_7EAA, 0);
    strobe();
    line(1'b1);
    check_all("R7 restart mode");
    check("R7 speed held", speed, 19'h3_1F0E & 9'h1FF);
    line(1'b1);
    check_all("R7 restart speed");

    // Directed: strobe in the same cycle as a readout line start
    send_word(19'h2_4C39, 0);
    ser_stb = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    line_start = 1'b1; rdout_act = 1'b1;
    @(negedge clk);
    line_start = 1'b0; rdout_act = 1'b0;
    wait_neg(2);
    ser_stb = 1'b0; wait_neg(3);
    model_strobe();
    check_all("R7 coincident strobe no commit");
    line(1'b1);
    check_all("R7 coincident then mode");
    line(1'b1);
    check_all("R7 coincident then speed");

    // Random mix
    for (int it = 0; it < 60; it++) begin
      logic [18:0] w = 19'($urandom);
      send_word(w, int'($urandom_range(0, 4)));
      if ($urandom_range(0, 4) != 0) begin
        strobe();
        check_all("R3 random strobe");
      end else begin
        check_all("R8 random no strobe");
      end
      for (int k = 0; k < int'($urandom_range(0, 4)); k++) begin
        line(1'($urandom));
        check_all("R4 R5 R6 random line");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule